// File: doc/BRIEF.md
# Four-State Debug Trigger Sequencer

This block decides when a debug session fires. After an arm input goes high it walks through three intermediate states toward a final state. Each intermediate state has its own source mask and its own programmed successor. Entering the final state produces a one-cycle session trigger for the tracing logic and, when one is configured, a one-cycle breakpoint request. Comparator matches arrive as pulses. Each comparator is configured as either tagged or forced. A tagged match marks the fetched instruction and acts only when that instruction is about to begin execution. A forced match acts at the first instruction boundary after the match. An external tag input is handled as one more tagged source.

A software trigger and a coprocessor breakpoint request both bypass the comparators and move the sequencer straight to the final state. A flush input drops pending tags whose instructions will never execute. A suspend input stops comparator-driven monitoring without losing any pending trigger. The comparators and the trace memory sit outside this block.

Top module: `trig_sequencer`

## Requirements
- R1: After reset, `curState` is 0 (idle), and `finalTrig` and `brkReq` are 0.
- R2: While `armEn` is low, `curState` is 0 from the next edge onward, and all pending tags and forced matches are cleared. When `armEn` is high in idle, `curState` becomes 1 at the next edge.
- R3: State codes are 0 for idle, 1 to 3 for the intermediate states, and 4 for final. The final state holds for as long as `armEn` stays high.
- R4: A comparator whose `cfgTagMode` bit is 1 records a pending tag on a `matchPulse` edge. The state advances at a later edge where `tagHit` of that source is high, the tag is pending, and the source's mask bit is set. A `tagHit` sampled in the same cycle as the match does not advance the state. Any unsuspended `tagHit` consumes the tag of its source.
- R5: A comparator whose `cfgTagMode` bit is 0 records a pending forced match. The state advances at the first later edge with `instBoundary` high. A boundary in the same cycle as the match does not count. Any unsuspended boundary consumes all forced matches, whether masked or not.
- R6: The mask for state s is `cfgMask[(s-1)*5 +: 5]`. Bit i (i=0..3) enables comparator i, and bit 4 enables the external tag. A source whose bit is 0 never advances that state.
- R7: The successor of state s is `cfgNext[(s-1)*3 +: 3]`. A code of 0, or any code above 4, selects the final state. Every transition clears all pending tags and forced matches.
- R8: `swTrig` high in any armed, non-final state, idle included, moves to the final state at the next edge.
- R9: `extTag` records a pending tag for source 4. That tag acts through `tagHit[4]` under mask bit 4, following the tagged rules.
- R10: `flush` clears all pending tags, including one recorded in the same cycle. It leaves forced matches untouched.
- R11: While `suspend` is high, matches are not recorded, pending state is neither used nor consumed, and the state does not advance through comparators or tags. `swTrig` and `copBrkReq` still act.
- R12: `finalTrig` is high for exactly the first cycle in which `curState` is 4.
- R13: `brkReq` pulses together with `finalTrig`, decoded from `cfgBrkAct`: 0 gives none, 1 gives bit 0 (enter monitor), 2 gives bit 1 (software interrupt), and 3 gives bit 2 (coprocessor break).
- R14: `copBrkReq` in any armed, non-final state moves to the final state with `brkReq` = 3'b100, whatever `cfgBrkAct` holds. It takes priority over `swTrig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| armEn | input | 1 | Arm level; low returns to idle |
| swTrig | input | 1 | Software trigger, jumps to final |
| copBrkReq | input | 1 | Coprocessor breakpoint request, jumps to final |
| extTag | input | 1 | External tag of the instruction being fetched |
| suspend | input | 1 | Suspends comparator and tag monitoring |
| flush | input | 1 | Pipeline flush, drops pending tags |
| instBoundary | input | 1 | Instruction boundary strobe |
| matchPulse | input | 4 | Comparator match pulses |
| tagHit | input | 5 | Tagged instruction of source i is about to execute (bit 4 is external) |
| cfgTagMode | input | 4 | Per comparator: 1 tagged, 0 forced |
| cfgMask | input | 15 | Source masks for states 1 to 3 |
| cfgNext | input | 9 | Successor codes for states 1 to 3 |
| cfgBrkAct | input | 2 | Breakpoint action selector |
| curState | output | 3 | Current state code |
| finalTrig | output | 1 | Session trigger pulse |
| brkReq | output | 3 | One-hot breakpoint request pulse |

## Verification
Every result lands one edge after the inputs that cause it. A transition, `finalTrig` and `brkReq` all appear in the cycle after the decisive `tagHit`, `instBoundary`, `swTrig` or `copBrkReq`. A recorded match can act no earlier than the edge after the one that records it. The bench drives inputs one time unit after a rising edge and compares outputs one time unit after the next rising edge, against a reference model that it steps once per edge. Directed sequences first place the match and the trigger strobe in the same cycle, then in consecutive cycles, so that the one-edge delay for recording is exercised in both directions.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  // Strobes from the sequencing control to the pending/output datapath
  typedef struct packed {
    logic clrPend;     // drop every pending tag and forced match
    logic capEn;       // monitoring live: record matches, consume hits
    logic enterFinal;  // final state is entered at this edge
    logic copEntry;    // entry caused by the coprocessor request
  } seqStrobe_t;

  localparam logic [1:0] ACT_NONE = 2'd0;
  localparam logic [1:0] ACT_MON  = 2'd1;
  localparam logic [1:0] ACT_SWI  = 2'd2;
  localparam logic [1:0] ACT_COP  = 2'd3;

  localparam int BRK_MON = 0;
  localparam int BRK_SWI = 1;
  localparam int BRK_COP = 2;
  localparam int BRK_W   = 3;

endpackage

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_seq_pkg::*;
#(
  parameter int NUM_STATES = 4,
  localparam int STW = $clog2(NUM_STATES + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          armEn,
  input  logic                          swTrig,
  input  logic                          copBrk,
  input  logic                          suspend,
  input  logic                          fireAny,
  input  logic [(NUM_STATES-1)*STW-1:0] cfgNext,
  output logic [STW-1:0]                curState,
  output seqStrobe_t                    strobe
);

  localparam logic [STW-1:0] IDLE_CODE  = '0;
  localparam logic [STW-1:0] FIRST_CODE = STW'(1);
  localparam logic [STW-1:0] FINAL_CODE = STW'(NUM_STATES);

  logic [STW-1:0] stNext;
  logic [STW-1:0] selNext;
  logic           advance;
  logic           copHit;

  function automatic logic [STW-1:0] mapNext(input logic [STW-1:0] code);
    if (code == IDLE_CODE || code > FINAL_CODE) return FINAL_CODE;
    return code;
  endfunction

  // successor field of the current intermediate state
  always_comb begin
    selNext = FINAL_CODE;
    for (int s = 0; s < NUM_STATES - 1; s++) begin
      if (curState == STW'(s + 1)) selNext = cfgNext[s*STW +: STW];
    end
  end

  always_comb begin
    stNext  = curState;
    advance = 1'b0;
    copHit  = 1'b0;
    if (!armEn) begin
      stNext = IDLE_CODE;
    end else if (curState == FINAL_CODE) begin
      stNext = FINAL_CODE;
    end else if (copBrk) begin
      stNext = FINAL_CODE;
      copHit = 1'b1;
    end else if (swTrig) begin
      stNext = FINAL_CODE;
    end else if (curState == IDLE_CODE) begin
      stNext = FIRST_CODE;
    end else if (!suspend && fireAny) begin
      stNext  = mapNext(selNext);
      advance = 1'b1;
    end
  end

  always_comb begin
    strobe.clrPend    = !armEn || (curState == IDLE_CODE) || advance || (stNext != curState);
    strobe.capEn      = armEn && !suspend;
    strobe.enterFinal = armEn && (stNext == FINAL_CODE) && (curState != FINAL_CODE);
    strobe.copEntry   = copHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= IDLE_CODE;
    else       curState <= stNext;
  end

  AST_IDLE_WHEN_DISARMED: assert property (@(posedge clk) disable iff (!rstN)
    !armEn |=> curState == IDLE_CODE);  // R2
  AST_FINAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (curState == FINAL_CODE && armEn) |=> curState == FINAL_CODE);  // R3
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    curState <= FINAL_CODE);  // R3
  AST_SWTRIG_JUMP: assert property (@(posedge clk) disable iff (!rstN)
    (armEn && swTrig) |=> curState == FINAL_CODE);  // R8
  AST_SUSPEND_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (armEn && suspend && !swTrig && !copBrk && curState != IDLE_CODE) |=> $stable(curState));  // R11

endmodule

// File: rtl/trig_seq_dp.sv
module trig_seq_dp
  import trig_seq_pkg::*;
#(
  parameter int NUM_STATES = 4,
  parameter int NUM_CMP    = 4,
  localparam int NUM_SRC   = NUM_CMP + 1,
  localparam int STW       = $clog2(NUM_STATES + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_CMP-1:0]                matchPulse,
  input  logic [NUM_SRC-1:0]                tagHit,
  input  logic                              extTag,
  input  logic                              instBoundary,
  input  logic                              flush,
  input  logic [NUM_CMP-1:0]                cfgTagMode,
  input  logic [(NUM_STATES-1)*NUM_SRC-1:0] cfgMask,
  input  logic [1:0]                        cfgBrkAct,
  input  logic [STW-1:0]                    curState,
  input  seqStrobe_t                        strobe,
  output logic                              fireAny,
  output logic                              finalTrig,
  output logic [BRK_W-1:0]                  brkReq
);

  localparam int EXT_IDX = NUM_CMP;

  logic [NUM_SRC-1:0] tagPend;
  logic [NUM_SRC-1:0] tagSet;
  logic [NUM_SRC-1:0] stateMask;
  logic [NUM_CMP-1:0] forcePend;
  logic [NUM_CMP-1:0] forceSet;
  logic [BRK_W-1:0]   brkNext;
  logic               fireTag;
  logic               fireForce;

  // per-source classification of incoming matches
  generate
    for (genvar i = 0; i < NUM_CMP; i++) begin : gCmpSrc
      assign tagSet[i]   = matchPulse[i] &  cfgTagMode[i];
      assign forceSet[i] = matchPulse[i] & ~cfgTagMode[i];
    end
  endgenerate
  assign tagSet[EXT_IDX] = extTag;

  // mask of the current intermediate state; idle and final enable nothing
  always_comb begin
    stateMask = '0;
    for (int s = 0; s < NUM_STATES - 1; s++) begin
      if (curState == STW'(s + 1)) stateMask = cfgMask[s*NUM_SRC +: NUM_SRC];
    end
  end

  assign fireTag   = |(tagPend & tagHit & stateMask);
  assign fireForce = instBoundary & |(forcePend & stateMask[NUM_CMP-1:0]);
  assign fireAny   = fireTag | fireForce;

  // pending tags: flush and clear win, a new match beats a same-cycle hit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagPend <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (strobe.clrPend || flush)             tagPend[i] <= 1'b0;
        else if (strobe.capEn && tagSet[i])      tagPend[i] <= 1'b1;
        else if (strobe.capEn && tagHit[i])      tagPend[i] <= 1'b0;
      end
    end
  end

  // pending forced matches: consumed by any live boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      forcePend <= '0;
    end else begin
      for (int i = 0; i < NUM_CMP; i++) begin
        if (strobe.clrPend)                      forcePend[i] <= 1'b0;
        else if (strobe.capEn && forceSet[i])    forcePend[i] <= 1'b1;
        else if (strobe.capEn && instBoundary)   forcePend[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    brkNext = '0;
    if (strobe.enterFinal) begin
      if (strobe.copEntry) begin
        brkNext[BRK_COP] = 1'b1;
      end else begin
        case (cfgBrkAct)
          ACT_MON:  brkNext[BRK_MON] = 1'b1;
          ACT_SWI:  brkNext[BRK_SWI] = 1'b1;
          ACT_COP:  brkNext[BRK_COP] = 1'b1;
          default:  brkNext = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      finalTrig <= 1'b0;
      brkReq    <= '0;
    end else begin
      finalTrig <= strobe.enterFinal;
      brkReq    <= brkNext;
    end
  end

  AST_FLUSH_DROPS_TAGS: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> tagPend == '0);  // R10
  AST_SUSPEND_KEEPS_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.capEn && !strobe.clrPend) |=> $stable(forcePend));  // R11
  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    finalTrig |=> !finalTrig);  // R12
  AST_BRK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(brkReq));  // R13

endmodule

// File: rtl/trig_sequencer.sv
module trig_sequencer
  import trig_seq_pkg::*;
#(
  parameter int NUM_STATES = 4,
  parameter int NUM_CMP    = 4,
  localparam int NUM_SRC   = NUM_CMP + 1,
  localparam int STW       = $clog2(NUM_STATES + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              armEn,
  input  logic                              swTrig,
  input  logic                              copBrkReq,
  input  logic                              extTag,
  input  logic                              suspend,
  input  logic                              flush,
  input  logic                              instBoundary,
  input  logic [NUM_CMP-1:0]                matchPulse,
  input  logic [NUM_SRC-1:0]                tagHit,
  input  logic [NUM_CMP-1:0]                cfgTagMode,
  input  logic [(NUM_STATES-1)*NUM_SRC-1:0] cfgMask,
  input  logic [(NUM_STATES-1)*STW-1:0]     cfgNext,
  input  logic [1:0]                        cfgBrkAct,
  output logic [STW-1:0]                    curState,
  output logic                              finalTrig,
  output logic [BRK_W-1:0]                  brkReq
);

  localparam logic [STW-1:0] FINAL_CODE = STW'(NUM_STATES);

  seqStrobe_t strobe;
  logic       fireAny;

  trig_seq_ctrl #(.NUM_STATES(NUM_STATES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .armEn    (armEn),
    .swTrig   (swTrig),
    .copBrk   (copBrkReq),
    .suspend  (suspend),
    .fireAny  (fireAny),
    .cfgNext  (cfgNext),
    .curState (curState),
    .strobe   (strobe)
  );

  trig_seq_dp #(.NUM_STATES(NUM_STATES), .NUM_CMP(NUM_CMP)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .matchPulse   (matchPulse),
    .tagHit       (tagHit),
    .extTag       (extTag),
    .instBoundary (instBoundary),
    .flush        (flush),
    .cfgTagMode   (cfgTagMode),
    .cfgMask      (cfgMask),
    .cfgBrkAct    (cfgBrkAct),
    .curState     (curState),
    .strobe       (strobe),
    .fireAny      (fireAny),
    .finalTrig    (finalTrig),
    .brkReq       (brkReq)
  );

  AST_TRIG_IN_FINAL: assert property (@(posedge clk) disable iff (!rstN)
    finalTrig |-> curState == FINAL_CODE);  // R12
  AST_TRIG_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (curState == FINAL_CODE && $past(curState) != FINAL_CODE) |-> finalTrig);  // R12

endmodule

// File: tb/sim_trig_sequencer.sv
module sim_trig_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NCMP = 4;
  localparam int NSRC = 5;
  localparam int NST  = 4;
  localparam int SW   = 3;
  localparam logic [2:0] FIN = 3'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armEn = 0, swTrig = 0, copBrkReq = 0, extTag = 0, suspend = 0, flush = 0, instBoundary = 0;
  logic [NCMP-1:0] matchPulse = '0;
  logic [NSRC-1:0] tagHit = '0;
  logic [NCMP-1:0] cfgTagMode = '0;
  logic [(NST-1)*NSRC-1:0] cfgMask = '0;
  logic [(NST-1)*SW-1:0] cfgNext = '0;
  logic [1:0] cfgBrkAct = '0;
  logic [2:0] curState;
  logic finalTrig;
  logic [2:0] brkReq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  logic [2:0] mState = '0;
  logic [NSRC-1:0] mTag = '0;
  logic [NCMP-1:0] mForce = '0;
  logic mTrig = 0;
  logic [2:0] mBrk = '0;

  trig_sequencer u0 (
    .clk(clk), .rstN(rstN), .armEn(armEn), .swTrig(swTrig), .copBrkReq(copBrkReq),
    .extTag(extTag), .suspend(suspend), .flush(flush), .instBoundary(instBoundary),
    .matchPulse(matchPulse), .tagHit(tagHit), .cfgTagMode(cfgTagMode), .cfgMask(cfgMask),
    .cfgNext(cfgNext), .cfgBrkAct(cfgBrkAct), .curState(curState), .finalTrig(finalTrig),
    .brkReq(brkReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] decodeBrk(input logic [1:0] act);
    case (act)
      2'd1: return 3'b001;
      2'd2: return 3'b010;
      2'd3: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic clearPulses();
    swTrig = 0; copBrkReq = 0; extTag = 0; flush = 0; instBoundary = 0;
    matchPulse = '0; tagHit = '0;
  endtask

  // one clock edge: model advances from the applied inputs, outputs compared after the edge
  task automatic step();
    logic [NSRC-1:0] msk, tset;
    logic [NCMP-1:0] fset;
    logic [2:0] ns, nx, brk;
    logic adv, cop, ft, ff, cap, clr, ent;
    msk = '0;
    if (mState >= 3'd1 && mState <= 3'd3) msk = cfgMask[(int'(mState)-1)*NSRC +: NSRC];
    tset = {extTag, matchPulse & cfgTagMode};
    fset = matchPulse & ~cfgTagMode;
    ft = |(mTag & tagHit & msk);
    ff = instBoundary & |(mForce & msk[NCMP-1:0]);
    ns = mState; adv = 0; cop = 0;
    if (!armEn) ns = 3'd0;
    else if (mState == FIN) ns = FIN;
    else if (copBrkReq) begin ns = FIN; cop = 1; end
    else if (swTrig) ns = FIN;
    else if (mState == 3'd0) ns = 3'd1;
    else if (!suspend && (ft || ff)) begin
      nx = cfgNext[(int'(mState)-1)*SW +: SW];
      ns = (nx == 3'd0 || nx > FIN) ? FIN : nx;
      adv = 1;
    end
    cap = armEn && !suspend;
    clr = !armEn || mState == 3'd0 || adv || ns != mState;
    ent = armEn && ns == FIN && mState != FIN;
    brk = '0;
    if (ent) brk = cop ? 3'b100 : decodeBrk(cfgBrkAct);
    @(posedge clk);
    #1;
    for (int i = 0; i < NSRC; i++) begin
      if (clr || flush) mTag[i] = 0;
      else if (cap && tset[i]) mTag[i] = 1;
      else if (cap && tagHit[i]) mTag[i] = 0;
    end
    for (int i = 0; i < NCMP; i++) begin
      if (clr) mForce[i] = 0;
      else if (cap && fset[i]) mForce[i] = 1;
      else if (cap && instBoundary) mForce[i] = 0;
    end
    mState = ns; mTrig = ent; mBrk = brk;
    chk("MODEL state", int'(curState), int'(mState));
    chk("MODEL finalTrig", int'(finalTrig), int'(mTrig));
    chk("MODEL brkReq", int'(brkReq), int'(mBrk));
    clearPulses();
  endtask

  task automatic rearm();
    armEn = 0; step();
    armEn = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    chk("R1 state", int'(curState), 0);
    chk("R1 finalTrig", int'(finalTrig), 0);
    chk("R1 brkReq", int'(brkReq), 0);

    cfgTagMode = 4'b0001;
    cfgMask = {5'b00100, 5'b00010, 5'b00001};
    cfgNext = {3'd0, 3'd3, 3'd2};
    cfgBrkAct = 2'd1;
    step(); chk("R2 disarmed idle", int'(curState), 0);
    armEn = 1; step(); chk("R2 arm to state 1", int'(curState), 1);

    matchPulse = 4'b0001; tagHit = 5'b00001; step();
    chk("R4 same-cycle hit ignored", int'(curState), 1);
    tagHit = 5'b00001; step(); chk("R4 tagged advance", int'(curState), 2);

    matchPulse = 4'b0010; instBoundary = 1; step();
    chk("R5 same-cycle boundary ignored", int'(curState), 2);
    instBoundary = 1; step(); chk("R5 forced advance", int'(curState), 3);

    matchPulse = 4'b1000; step();
    instBoundary = 1; step(); chk("R6 masked source", int'(curState), 3);

    matchPulse = 4'b0100; step();
    instBoundary = 1; step();
    chk("R7 code 0 selects final", int'(curState), 4);
    chk("R12 trigger pulse", int'(finalTrig), 1);
    chk("R13 monitor request", int'(brkReq), 1);
    step();
    chk("R3 final holds", int'(curState), 4);
    chk("R12 single cycle", int'(finalTrig), 0);
    chk("R13 request single cycle", int'(brkReq), 0);

    armEn = 0; step(); chk("R2 disarm to idle", int'(curState), 0);
    armEn = 1; step();
    cfgBrkAct = 2'd2; swTrig = 1; step();
    chk("R8 software jump", int'(curState), 4);
    chk("R13 swi request", int'(brkReq), 2);

    armEn = 0; step(); armEn = 1;
    cfgBrkAct = 2'd1; copBrkReq = 1; swTrig = 1; step();
    chk("R14 coprocessor jump from idle", int'(curState), 4);
    chk("R14 coprocessor request", int'(brkReq), 4);

    rearm();
    cfgMask[4:0] = 5'b10000;
    extTag = 1; step();
    tagHit = 5'b10000; step(); chk("R9 external tag advance", int'(curState), 2);

    rearm();
    cfgMask[4:0] = 5'b00011;
    matchPulse = 4'b0001; step();
    flush = 1; step();
    tagHit = 5'b00001; step(); chk("R10 flushed tag dropped", int'(curState), 1);
    matchPulse = 4'b0010; step();
    flush = 1; step();
    instBoundary = 1; step(); chk("R10 forced kept over flush", int'(curState), 2);

    rearm();
    cfgMask[4:0] = 5'b00010;
    matchPulse = 4'b0010; step();
    armEn = 0; step(); armEn = 1; step();
    instBoundary = 1; step(); chk("R2 disarm clears pending", int'(curState), 1);

    suspend = 1; matchPulse = 4'b0010; step(); suspend = 0;
    instBoundary = 1; step(); chk("R11 no capture while suspended", int'(curState), 1);
    matchPulse = 4'b0010; step();
    suspend = 1; instBoundary = 1; step(); chk("R11 no advance while suspended", int'(curState), 1);
    suspend = 0; instBoundary = 1; step(); chk("R11 pending retained", int'(curState), 2);
    suspend = 1; swTrig = 1; step(); chk("R11 software trigger while suspended", int'(curState), 4);
    suspend = 0;

    rearm();
    cfgTagMode = 4'b0000;
    cfgMask = {5'b00100, 5'b00010, 5'b00001};
    cfgNext = {3'd0, 3'd6, 3'd2};
    matchPulse = 4'b0011; step();
    instBoundary = 1; step(); chk("R7 advance to programmed state", int'(curState), 2);
    instBoundary = 1; step(); chk("R7 transition cleared pending", int'(curState), 2);
    matchPulse = 4'b0010; step();
    instBoundary = 1; step(); chk("R7 code above final selects final", int'(curState), 4);

    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) begin
        cfgTagMode = 4'($urandom);
        cfgMask = 15'($urandom);
        cfgNext = 9'($urandom);
        cfgBrkAct = 2'($urandom);
      end
      armEn = ($urandom % 64) != 0;
      swTrig = ($urandom % 60) == 0;
      copBrkReq = ($urandom % 90) == 0;
      suspend = ($urandom % 8) == 0;
      flush = ($urandom % 16) == 0;
      instBoundary = ($urandom % 2) == 0;
      extTag = ($urandom % 8) == 0;
      for (int i = 0; i < NCMP; i++) matchPulse[i] = ($urandom % 6) == 0;
      for (int i = 0; i < NSRC; i++) tagHit[i] = ($urandom % 4) == 0;
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule